// File: doc/BRIEF.md
# UART Modem Flow-Control Unit

This unit sits beside a UART's transmitter and receive buffer and looks after the modem handshake lines. The clear-to-send input arrives from the remote side with no fixed timing. It is synchronized and then reported to the host as a status bit. A sticky change flag records each transition of that input and can raise an interrupt. The unit also drives the request-to-send output, which tells the remote side whether this receiver can accept data. Both lines are active low.

With automatic flow control off, the host drives request-to-send directly through a control bit, and clear-to-send only feeds the status register. With automatic flow control on, the unit gives the transmitter permission to start each byte only while the synchronized clear-to-send is asserted. It also deasserts request-to-send whenever the receive buffer holds more bytes than a programmable threshold. A byte that has already begun is not the unit's concern: it only controls when bytes may start. Loopback mode keeps request-to-send inactive.

Top module: `uart_flowctl`

## Requirements
- R1: After reset, rts_n_o is 1, msr_o reads 0 while cts_n_i is held high, and irq_o is 0.
- R2: msr_o bit 4 is the inverse of cts_n_i, taken through a two-flop synchronizer. It does not change at the first rising edge after an input change, and does change by the second.
- R3: msr_o bit 0 (change flag) sets one edge after the synchronized clear-to-send changes. It stays set until a cycle with msr_rd_i high, after which it reads 0.
- R4: irq_o is 1 exactly when the change flag is set and irq_en_i is 1. With irq_en_i at 0, irq_o stays 0.
- R5: With automatic flow control off (control bit 5 = 0), tx_go_o equals tx_req_i whatever cts_n_i is.
- R6: With automatic flow control and loopback off, rts_n_o is the inverse of control bit 1, one edge after the register holds the new value.
- R7: With automatic flow control on, tx_go_o is 0 while the synchronized clear-to-send is high, and follows tx_req_i while it is low.
- R8: With automatic flow control on and loopback off, rts_n_o is 1 one edge after rx_level_i exceeds the threshold, and 0 once rx_level_i is at or below it.
- R9: With loopback on (control bit 4 = 1), rts_n_o is 1 whatever the other control bits and the receive level are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_n_i | input | 1 | Clear-to-send from the remote side, active low, asynchronous |
| rts_n_o | output | 1 | Request-to-send to the remote side, active low |
| ctl_we_i | input | 1 | Write strobe for the control register |
| ctl_wdata_i | input | 8 | Control data: bit 1 request, bit 4 loopback, bit 5 automatic flow |
| thr_we_i | input | 1 | Write strobe for the receive threshold |
| thr_wdata_i | input | LVL_W | New receive threshold |
| msr_rd_i | input | 1 | Status read strobe; clears the change flag |
| msr_o | output | 8 | Status: bit 4 clear-to-send asserted, bit 0 change flag |
| irq_en_i | input | 1 | Modem-status interrupt enable |
| irq_o | output | 1 | Modem-status interrupt |
| tx_req_i | input | 1 | Transmitter wants to start a byte |
| tx_go_o | output | 1 | Permission to start that byte |
| rx_level_i | input | LVL_W | Current receive buffer fill level |

## Verification
The bound assertions watch the following on every cycle. No start permit is given without a request. No permit is given in automatic mode while clear-to-send is deasserted. The interrupt is masked when its enable is low. The change flag persists until a read. Request-to-send stays inactive under loopback and above the threshold. The bench scenarios are needed for the rest: the exact synchronizer latency, the read that clears the flag, the manual drive of request-to-send, and the return to ready once the level falls back to the threshold.

// File: rtl/uart_flowctl.sv
module uart_flowctl #(
  parameter int DEPTH   = 16,
  parameter int LVL_W   = $clog2(DEPTH + 1),
  parameter int THR_RST = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cts_n_i,
  output logic             rts_n_o,
  input  logic             ctl_we_i,
  input  logic [7:0]       ctl_wdata_i,
  input  logic             thr_we_i,
  input  logic [LVL_W-1:0] thr_wdata_i,
  input  logic             msr_rd_i,
  output logic [7:0]       msr_o,
  input  logic             irq_en_i,
  output logic             irq_o,
  input  logic             tx_req_i,
  output logic             tx_go_o,
  input  logic [LVL_W-1:0] rx_level_i
);
  localparam int BIT_REQ  = 1;
  localparam int BIT_LOOP = 4;
  localparam int BIT_AUTO = 5;

  logic             req_q, loop_q, auto_q;
  logic [LVL_W-1:0] thr_q;
  logic             cts_meta, cts_sync, cts_prev;
  logic             dcts_q;
  logic             rts_q;
  logic             rts_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      loop_q <= 1'b0;
      auto_q <= 1'b0;
    end else if (ctl_we_i) begin
      req_q  <= ctl_wdata_i[BIT_REQ];
      loop_q <= ctl_wdata_i[BIT_LOOP];
      auto_q <= ctl_wdata_i[BIT_AUTO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        thr_q <= LVL_W'(THR_RST);
    else if (thr_we_i) thr_q <= thr_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_meta <= 1'b1;
      cts_sync <= 1'b1;
      cts_prev <= 1'b1;
    end else begin
      cts_meta <= cts_n_i;
      cts_sync <= cts_meta;
      cts_prev <= cts_sync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    dcts_q <= 1'b0;
    else if (cts_sync != cts_prev) dcts_q <= 1'b1;
    else if (msr_rd_i)             dcts_q <= 1'b0;
  end

  always_comb begin
    if (loop_q)      rts_next = 1'b1;
    else if (auto_q) rts_next = (rx_level_i > thr_q);
    else             rts_next = ~req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_q <= 1'b1;
    else        rts_q <= rts_next;
  end

  assign rts_n_o = rts_q;
  assign msr_o   = {3'b000, ~cts_sync, 3'b000, dcts_q};
  assign irq_o   = dcts_q & irq_en_i;
  assign tx_go_o = tx_req_i & (~auto_q | ~cts_sync);

endmodule

module uart_flowctl_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rts_n_o,
  input logic [7:0]       msr_o,
  input logic             msr_rd_i,
  input logic             irq_en_i,
  input logic             irq_o,
  input logic             tx_req_i,
  input logic             tx_go_o,
  input logic [LVL_W-1:0] rx_level_i,
  input logic [LVL_W-1:0] thr_q,
  input logic             loop_q,
  input logic             auto_q
);
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) !irq_en_i |-> !irq_o); // R4
  AST_NO_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) tx_go_o |-> tx_req_i); // R5
  AST_AUTO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) (auto_q && !msr_o[4]) |-> !tx_go_o); // R7
  AST_DCTS_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (msr_o[0] && !msr_rd_i) |=> msr_o[0]); // R3
  AST_LOOP_RTS:   assert property (@(posedge clk) disable iff (!rst_n) loop_q |=> rts_n_o); // R9
  AST_AUTO_FULL:  assert property (@(posedge clk) disable iff (!rst_n) (auto_q && !loop_q && rx_level_i > thr_q) |=> rts_n_o); // R8
endmodule

bind uart_flowctl uart_flowctl_chk #(.LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rts_n_o(rts_n_o), .msr_o(msr_o), .msr_rd_i(msr_rd_i),
  .irq_en_i(irq_en_i), .irq_o(irq_o), .tx_req_i(tx_req_i), .tx_go_o(tx_go_o),
  .rx_level_i(rx_level_i), .thr_q(thr_q), .loop_q(loop_q), .auto_q(auto_q)
);

// File: tb/uart_flowctl_tb_top.sv
module uart_flowctl_tb_top;
  localparam int LVL_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_n_i = 1'b1, ctl_we_i = 1'b0, thr_we_i = 1'b0, msr_rd_i = 1'b0;
  logic irq_en_i = 1'b0, tx_req_i = 1'b0;
  logic [7:0] ctl_wdata_i = 8'h00;
  logic [LVL_W-1:0] thr_wdata_i = '0, rx_level_i = '0;
  logic rts_n_o, irq_o, tx_go_o;
  logic [7:0] msr_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_flowctl #(.DEPTH(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cts_n_i(cts_n_i), .rts_n_o(rts_n_o),
    .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i), .thr_we_i(thr_we_i),
    .thr_wdata_i(thr_wdata_i), .msr_rd_i(msr_rd_i), .msr_o(msr_o),
    .irq_en_i(irq_en_i), .irq_o(irq_o), .tx_req_i(tx_req_i), .tx_go_o(tx_go_o),
    .rx_level_i(rx_level_i)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(logic [7:0] v);
    ctl_wdata_i = v; ctl_we_i = 1'b1; tick(1); ctl_we_i = 1'b0;
  endtask

  task automatic wr_thr(logic [LVL_W-1:0] v);
    thr_wdata_i = v; thr_we_i = 1'b1; tick(1); thr_we_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rts_n after reset", rts_n_o, 1);
    chk("R1 msr after reset", msr_o, 0);
    chk("R1 irq after reset", irq_o, 0);
  endtask

  task automatic t_status;
    cts_n_i = 1'b0;
    tick(1);
    chk("R2 cts bit before second edge", msr_o[4], 0);
    tick(1);
    chk("R2 cts bit after second edge", msr_o[4], 1);
    tick(1);
    chk("R3 change flag set", msr_o[0], 1);
    irq_en_i = 1'b1; #1;
    chk("R4 irq enabled", irq_o, 1);
    irq_en_i = 1'b0; #1;
    chk("R4 irq masked", irq_o, 0);
    tick(2);
    chk("R3 flag held without read", msr_o[0], 1);
    msr_rd_i = 1'b1; tick(1); msr_rd_i = 1'b0;
    chk("R3 flag cleared by read", msr_o[0], 0);
    irq_en_i = 1'b1; #1;
    chk("R4 irq low after clear", irq_o, 0);
    irq_en_i = 1'b0;
    tick(2);
    chk("R3 flag stays clear", msr_o[0], 0);
  endtask

  task automatic t_manual;
    wr_ctl(8'h02); tick(1);
    chk("R6 request drives rts_n low", rts_n_o, 0);
    wr_ctl(8'h00); tick(1);
    chk("R6 request clear drives rts_n high", rts_n_o, 1);
    cts_n_i = 1'b1; tick(3);
    tx_req_i = 1'b1; #1;
    chk("R5 go ignores cts when manual", tx_go_o, 1);
    tx_req_i = 1'b0; #1;
    chk("R5 no go without request", tx_go_o, 0);
    msr_rd_i = 1'b1; tick(1); msr_rd_i = 1'b0;
  endtask

  task automatic t_auto;
    wr_ctl(8'h20); wr_thr(5'd4);
    rx_level_i = 5'd0; tick(1);
    chk("R8 ready below threshold", rts_n_o, 0);
    tx_req_i = 1'b1; #1;
    chk("R7 blocked while cts high", tx_go_o, 0);
    cts_n_i = 1'b0; tick(1); #1;
    chk("R7 still blocked during sync", tx_go_o, 0);
    tick(1);
    chk("R7 permitted when cts low", tx_go_o, 1);
    rx_level_i = 5'd5; tick(1);
    chk("R8 not ready above threshold", rts_n_o, 1);
    rx_level_i = 5'd4; tick(1);
    chk("R8 ready at threshold", rts_n_o, 0);
    cts_n_i = 1'b1; tick(2);
    chk("R7 blocked after cts rises", tx_go_o, 0);
    tx_req_i = 1'b0;
  endtask

  task automatic t_loop;
    wr_ctl(8'h12); tick(1);
    chk("R9 loopback overrides request", rts_n_o, 1);
    wr_ctl(8'h30); rx_level_i = 5'd0; tick(1);
    chk("R9 loopback overrides autoflow", rts_n_o, 1);
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(1);
    t_reset();
    t_status();
    t_manual();
    t_auto();
    t_loop();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule